// File: doc/BRIEF.md
# Sub-Word View Register File

This block holds four 64-bit architectural registers and lets a datapath reach each of them through five views: the whole register, its low 32 bits, its low 16 bits, its low byte, or the byte at bits 15:8. Two read ports and one write port each take a register index and a view code. Reads return the selected view as an unsigned value, zero-extended to 64 bits, together with the view's width in bits. Downstream arithmetic can use that width to trim its result.

A write through a narrow view merges into the register. Every bit outside the view keeps its value, and a 32-bit write is no exception. When the caller marks an access as two-operand, the block compares the widths of the two read views. If they differ, or if any active port carries a view code that has no meaning, it raises an error flag. All outputs are registered: read data, widths and the error flag appear one clock edge after the request.

Top module: `subview_regfile`

## Requirements
- R1: A synchronous active-high reset clears all four registers, both read-data outputs, both width outputs and the error flag.
- R2: View codes map as follows: 0 selects bits 63:0, 1 selects bits 31:0, 2 selects bits 15:0, 3 selects bits 7:0 and 4 selects bits 15:8. The register index is 2 bits.
- R3: A write with `wr_en` high and a valid view replaces only that view's bits. The low bits of `wr_data` feed the view: for view 4, `wr_data[7:0]` lands in bits 15:8. Every other bit keeps its value, including bits 63:32 on a 32-bit write.
- R4: Read data is the view's bits as an unsigned number, zero-extended to 64 bits. A view-4 read returns bits 15:8 in data bits 7:0.
- R5: The two read ports are independent and may select the same register and the same view in the same cycle.
- R6: A read of the register being written in the same cycle returns the value from before the write. The new value is visible to a read presented in the following cycle.
- R7: When `pair_chk` is high and both read views are valid but of different widths, `err` is high in the next cycle. It stays low when the widths match.
- R8: View codes 5 to 7 raise `err` when they appear on read port A, on read port B while `pair_chk` is high, or on the write port while `wr_en` is high. A write with such a code changes nothing. A read with such a code returns data 0 and width 0.
- R9: Each width output gives 64, 32, 16, 8 or 8 for views 0 to 4 respectively.
- R10: Read data, widths and `err` are registered. They reflect the inputs present at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write enable |
| wr_sel | input | 2 | Write register index |
| wr_view | input | 3 | Write view code |
| wr_data | input | 64 | Write data, low bits used for narrow views |
| ra_sel | input | 2 | Read port A register index |
| ra_view | input | 3 | Read port A view code |
| rb_sel | input | 2 | Read port B register index |
| rb_view | input | 3 | Read port B view code |
| pair_chk | input | 1 | Marks the access as two-operand; enables width comparison |
| ra_data | output | 64 | Read port A data, zero-extended |
| rb_data | output | 64 | Read port B data, zero-extended |
| ra_width | output | 7 | Width in bits of port A's view, 0 if invalid |
| rb_width | output | 7 | Width in bits of port B's view, 0 if invalid |
| err | output | 1 | Illegal view code or width mismatch |

## Verification
On every cycle, the assertions check the following:
- a narrow read never carries bits above its reported width;
- an invalid read yields zero data;
- a 32-bit write leaves bits 63:32 alone, and a write with a bad code leaves its target untouched;
- a width mismatch on a paired access raises the error flag;
- outputs are clear on the first edge after reset.

Only the bench's scenarios can show the rest, by comparing against a behavioural model on every clock:
- the values that the view merges produce;
- the high-byte shift on reads;
- the old value returned when a read and a write hit the same register in one cycle;
- two ports reading the same view at once.

// File: rtl/subview_pkg.sv
package subview_pkg;
  localparam int VIEW_W = 3;
  localparam int WID_W  = 7;

  typedef enum logic [VIEW_W-1:0] {
    VW_FULL = 3'd0,
    VW_WORD = 3'd1,
    VW_HALF = 3'd2,
    VW_LOB  = 3'd3,
    VW_HIB  = 3'd4
  } view_e;

  function automatic logic view_valid(input logic [VIEW_W-1:0] v);
    return v <= VW_HIB;
  endfunction

  function automatic logic [WID_W-1:0] view_bits(input logic [VIEW_W-1:0] v);
    case (v)
      VW_FULL: return 7'd64;
      VW_WORD: return 7'd32;
      VW_HALF: return 7'd16;
      VW_LOB,
      VW_HIB:  return 7'd8;
      default: return 7'd0;
    endcase
  endfunction
endpackage

// File: rtl/subview_merge.sv
module subview_merge
  import subview_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] old_val,
  input  logic [VIEW_W-1:0] view,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] new_val
);
  always_comb begin
    new_val = old_val;
    case (view)
      VW_FULL: new_val = din;
      VW_WORD: new_val[31:0] = din[31:0];
      VW_HALF: new_val[15:0] = din[15:0];
      VW_LOB:  new_val[7:0]  = din[7:0];
      VW_HIB:  new_val[15:8] = din[7:0];
      default: new_val = old_val;
    endcase
  end
endmodule

// File: rtl/subview_extract.sv
module subview_extract
  import subview_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] reg_val,
  input  logic [VIEW_W-1:0] view,
  output logic [DATA_W-1:0] dout,
  output logic [WID_W-1:0]  width
);
  always_comb begin
    dout = '0;
    case (view)
      VW_FULL: dout = reg_val;
      VW_WORD: dout[31:0] = reg_val[31:0];
      VW_HALF: dout[15:0] = reg_val[15:0];
      VW_LOB:  dout[7:0]  = reg_val[7:0];
      VW_HIB:  dout[7:0]  = reg_val[15:8];
      default: dout = '0;
    endcase
    width = view_bits(view);
  end
endmodule

// File: rtl/subview_check.sv
module subview_check
  import subview_pkg::*;
(
  input  logic [VIEW_W-1:0] a_view,
  input  logic [VIEW_W-1:0] b_view,
  input  logic              pair_chk,
  input  logic              wr_en,
  input  logic [VIEW_W-1:0] wr_view,
  output logic              wr_ok,
  output logic              err_next
);
  logic bad_a, bad_b, bad_w, mismatch;

  always_comb begin
    bad_a    = !view_valid(a_view);
    bad_b    = pair_chk && !view_valid(b_view);
    bad_w    = wr_en && !view_valid(wr_view);
    mismatch = pair_chk && (view_bits(a_view) != view_bits(b_view));
    wr_ok    = wr_en && view_valid(wr_view);
    err_next = bad_a || bad_b || bad_w || mismatch;
  end
endmodule

// File: rtl/subview_regfile.sv
module subview_regfile
  import subview_pkg::*;
#(
  parameter int NREG   = 4,
  parameter int DATA_W = 64,
  localparam int IDX_W = $clog2(NREG),
  localparam int NPORT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_sel,
  input  logic [VIEW_W-1:0] wr_view,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  ra_sel,
  input  logic [VIEW_W-1:0] ra_view,
  input  logic [IDX_W-1:0]  rb_sel,
  input  logic [VIEW_W-1:0] rb_view,
  input  logic              pair_chk,
  output logic [DATA_W-1:0] ra_data,
  output logic [DATA_W-1:0] rb_data,
  output logic [WID_W-1:0]  ra_width,
  output logic [WID_W-1:0]  rb_width,
  output logic              err
);
  logic [DATA_W-1:0] regs [NREG];
  logic [DATA_W-1:0] merged;
  logic              wr_ok, err_next;

  logic [IDX_W-1:0]  p_sel   [NPORT];
  logic [VIEW_W-1:0] p_view  [NPORT];
  logic [DATA_W-1:0] p_dnext [NPORT];
  logic [WID_W-1:0]  p_wnext [NPORT];
  logic [DATA_W-1:0] p_dq    [NPORT];
  logic [WID_W-1:0]  p_wq    [NPORT];

  assign p_sel[0]  = ra_sel;
  assign p_sel[1]  = rb_sel;
  assign p_view[0] = ra_view;
  assign p_view[1] = rb_view;

  subview_check u_check (
    .a_view(ra_view), .b_view(rb_view), .pair_chk(pair_chk),
    .wr_en(wr_en), .wr_view(wr_view), .wr_ok(wr_ok), .err_next(err_next)
  );

  subview_merge #(.DATA_W(DATA_W)) u_merge (
    .old_val(regs[wr_sel]), .view(wr_view), .din(wr_data), .new_val(merged)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs[i] <= '0;
      else if (wr_ok && wr_sel == IDX_W'(i))
        regs[i] <= merged;
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    subview_extract #(.DATA_W(DATA_W)) u_extract (
      .reg_val(regs[p_sel[p]]), .view(p_view[p]),
      .dout(p_dnext[p]), .width(p_wnext[p])
    );
    always_ff @(posedge clk) begin
      if (rst) begin
        p_dq[p] <= '0;
        p_wq[p] <= '0;
      end else begin
        p_dq[p] <= p_dnext[p];
        p_wq[p] <= p_wnext[p];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) err <= 1'b0;
    else     err <= err_next;
  end

  assign ra_data  = p_dq[0];
  assign rb_data  = p_dq[1];
  assign ra_width = p_wq[0];
  assign rb_width = p_wq[1];

  // Assertions
  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  always @(posedge clk) begin
    if (rst_q === 1'b1 && rst === 1'b0)
      assert_reset_clear_R1: assert (ra_data == '0 && rb_data == '0 && !err
                                     && ra_width == '0 && rb_width == '0);
  end

  assert_narrow_zero_ext_R4: assert property (@(posedge clk) disable iff (rst)
    (ra_width == 7'd8) |-> (ra_data[DATA_W-1:8] == '0));

  assert_half_zero_ext_R4: assert property (@(posedge clk) disable iff (rst)
    (rb_width == 7'd16) |-> (rb_data[DATA_W-1:16] == '0));

  assert_bad_read_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (ra_width == 7'd0) |-> (ra_data == '0));

  assert_word_keeps_upper_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_view == VW_WORD) |=>
      (regs[$past(wr_sel)][DATA_W-1:32] == $past(regs[wr_sel][DATA_W-1:32])));

  assert_bad_write_dropped_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_view > VW_HIB) |=> (regs[$past(wr_sel)] == $past(regs[wr_sel])));

  assert_width_mismatch_R7: assert property (@(posedge clk) disable iff (rst)
    (pair_chk && ra_view <= VW_HIB && rb_view <= VW_HIB &&
     view_bits(ra_view) != view_bits(rb_view)) |=> err);
endmodule

// File: tb/test_subview_regfile.sv
module test_subview_regfile;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [1:0]  wr_sel, ra_sel, rb_sel;
  logic [2:0]  wr_view, ra_view, rb_view;
  logic [63:0] wr_data;
  logic        pair_chk;
  logic [63:0] ra_data, rb_data;
  logic [6:0]  ra_width, rb_width;
  logic        err;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [63:0] m [4];
  logic [63:0] exp_a, exp_b;
  int          exp_wa, exp_wb;
  logic        exp_err;

  always #5 clk = ~clk;

  subview_regfile i_subview_regfile (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_view(wr_view),
    .wr_data(wr_data), .ra_sel(ra_sel), .ra_view(ra_view), .rb_sel(rb_sel),
    .rb_view(rb_view), .pair_chk(pair_chk), .ra_data(ra_data), .rb_data(rb_data),
    .ra_width(ra_width), .rb_width(rb_width), .err(err)
  );

  function automatic int vw(input logic [2:0] v);
    case (v)
      3'd0: return 64;
      3'd1: return 32;
      3'd2: return 16;
      3'd3, 3'd4: return 8;
      default: return 0;
    endcase
  endfunction

  function automatic logic [63:0] vmask(input int w);
    if (w == 64) return ~64'd0;
    return (64'd1 << w) - 64'd1;
  endfunction

  function automatic logic [63:0] vread(input logic [63:0] val, input logic [2:0] v);
    int sh = (v == 3'd4) ? 8 : 0;
    if (vw(v) == 0) return 64'd0;
    return (val >> sh) & vmask(vw(v));
  endfunction

  function automatic logic [63:0] vwrite(input logic [63:0] old, input logic [2:0] v,
                                         input logic [63:0] d);
    int sh = (v == 3'd4) ? 8 : 0;
    logic [63:0] mk;
    if (vw(v) == 0) return old;
    mk = vmask(vw(v));
    return (old & ~(mk << sh)) | ((d & mk) << sh);
  endfunction

  task automatic cmp64(input string req, input string what, input logic [63:0] act,
                       input logic [63:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  // One clock: inputs already driven; model updates at the edge, compare after.
  task automatic tick(input string req);
    @(posedge clk);
    if (rst) begin
      for (int i = 0; i < 4; i++) m[i] = 64'd0;
      exp_a = 0; exp_b = 0; exp_wa = 0; exp_wb = 0; exp_err = 0;
    end else begin
      exp_a  = vread(m[ra_sel], ra_view);
      exp_b  = vread(m[rb_sel], rb_view);
      exp_wa = vw(ra_view);
      exp_wb = vw(rb_view);
      exp_err = (vw(ra_view) == 0) || (wr_en && vw(wr_view) == 0) ||
                (pair_chk && (vw(rb_view) == 0 || vw(ra_view) != vw(rb_view)));
      if (wr_en) m[wr_sel] = vwrite(m[wr_sel], wr_view, wr_data);
    end
    @(negedge clk);
    cmp64(req, "ra_data", ra_data, exp_a);
    cmp64(req, "rb_data", rb_data, exp_b);
    cmp64(req, "ra_width", 64'(ra_width), 64'(exp_wa));
    cmp64(req, "rb_width", 64'(rb_width), 64'(exp_wb));
    cmp64(req, "err", 64'(err), 64'(exp_err));
  endtask

  task automatic op(input string req, input logic we, input logic [1:0] ws,
                    input logic [2:0] wv, input logic [63:0] wd,
                    input logic [1:0] as, input logic [2:0] av,
                    input logic [1:0] bs, input logic [2:0] bv, input logic pc);
    wr_en = we; wr_sel = ws; wr_view = wv; wr_data = wd;
    ra_sel = as; ra_view = av; rb_sel = bs; rb_view = bv; pair_chk = pc;
    tick(req);
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
    $finish;
  end

  initial begin
    rst = 1'b1;
    wr_en = 0; wr_sel = 0; wr_view = 0; wr_data = 0;
    ra_sel = 0; ra_view = 0; rb_sel = 0; rb_view = 0; pair_chk = 0;
    for (int i = 0; i < 3; i++) tick("R1");
    rst = 1'b0;
    // R1: registers read zero after reset
    for (int r = 0; r < 4; r++) op("R1", 0, 0, 0, 0, 2'(r), 0, 2'(r), 1, 0);

    // R2 / R10: full write, then readback on the following cycle
    op("R2", 1, 0, 0, 64'h0123_4567_89AB_CDEF, 0, 0, 0, 0, 0);
    op("R10", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R3: 32-bit write preserves upper bits
    op("R3", 1, 1, 0, ~64'd0, 1, 0, 1, 0, 0);
    op("R3", 1, 1, 1, 64'hFFFF_FFFF_0000_0000, 1, 0, 1, 1, 0);
    op("R3", 0, 0, 0, 0, 1, 0, 1, 1, 0);
    // R3: 16-bit, low byte, high byte merges
    op("R3", 1, 2, 0, 64'hDEAD_BEEF_CAFE_F00D, 2, 0, 2, 0, 0);
    op("R3", 1, 2, 2, 64'hFFFF_FFFF_FFFF_1234, 2, 0, 2, 2, 0);
    op("R3", 1, 2, 3, 64'h0000_0000_0000_0077, 2, 0, 2, 3, 0);
    op("R3", 1, 2, 4, 64'hFFFF_FFFF_FFFF_FFA5, 2, 0, 2, 4, 0);
    op("R3", 0, 0, 0, 0, 2, 0, 2, 4, 0);
    // R4 / R9: every view of register 0 on both ports
    for (int v = 0; v < 5; v++) op("R4", 0, 0, 0, 0, 0, 3'(v), 2, 3'(v), 0);
    for (int v = 0; v < 5; v++) op("R9", 0, 0, 0, 0, 1, 3'(v), 0, 3'(4 - v), 0);
    // R5: both ports same register and view
    op("R5", 0, 0, 0, 0, 2, 1, 2, 1, 1);
    op("R5", 0, 0, 0, 0, 0, 4, 0, 4, 1);
    // R6: read during write returns old value, new value next cycle
    op("R6", 1, 3, 0, 64'h5555_AAAA_5555_AAAA, 3, 0, 3, 2, 0);
    op("R6", 1, 3, 3, 64'h0000_0000_0000_0011, 3, 0, 3, 3, 0);
    op("R6", 0, 0, 0, 0, 3, 0, 3, 3, 0);
    // R7: width mismatch on a paired access, and matching widths
    op("R7", 0, 0, 0, 0, 0, 0, 1, 1, 1);
    op("R7", 0, 0, 0, 0, 0, 3, 1, 4, 1);
    op("R7", 0, 0, 0, 0, 0, 2, 1, 3, 0);
    // R8: invalid codes
    op("R8", 0, 0, 0, 0, 0, 7, 1, 0, 0);
    op("R8", 0, 0, 0, 0, 0, 0, 1, 5, 1);
    op("R8", 0, 0, 0, 0, 0, 0, 1, 6, 0);
    op("R8", 1, 0, 6, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 1, 0, 0);
    op("R8", 0, 0, 0, 0, 0, 0, 0, 0, 0);

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
    $finish;
  end
endmodule